// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block resolves the source operand of a load-style instruction. From a 3-bit mode code, a register specifier, a constant field and the current program counter, it computes an effective address. It then runs the memory reads that mode needs and delivers the operand with a one-cycle valid strobe. For the two auto-modify modes it also writes the updated address register back through a register-file write port.

A request is accepted on a cycle where `start_i` is high and the block is idle. The register specifier goes straight to the register-file read port, and its data is sampled in the accept cycle. Memory is a synchronous read port: data for a read issued in one cycle is present on `mem_rdata_i` in the next cycle. All address arithmetic wraps modulo 2^ADDR_W. An address read from memory uses the low ADDR_W bits of the data word. A value written back to a register is zero-extended to DATA_W.

Top module: `opnd_agu`

## Requirements
- R1: While reset is asserted and after its release with no request, `busy_o`, `opnd_valid_o`, `mem_re_o` and `rf_we_o` are low.
- R2: Mode 0 (immediate) makes no memory read. The operand is the constant field, zero-extended. `opnd_valid_o` is high in the first cycle after the accept edge.
- R3: Mode 1 (direct) makes one read at the constant field. The operand is that read's data, and it is valid in the cycle after the read.
- R4: Mode 2 (register indirect) makes one read at the low ADDR_W bits of the specified register. The operand is that read's data.
- R5: Mode 3 (memory indirect) makes two reads in back-to-back cycles. The first is at the constant field and the second at the low ADDR_W bits of the first read's data. The operand, the second read's data, is valid in the cycle after the second read.
- R6: Mode 4 (indexed) reads at register + field, and mode 5 (relative) reads at pc + field. Both sums wrap modulo 2^ADDR_W, and each mode makes exactly one read.
- R7: Mode 6 (post-increment) reads at the register value. In the same cycle as the read, it writes register + 1 (wrapping) to the same register exactly once.
- R8: Mode 7 (pre-decrement) reads at register − 1 (wrapping). In the same cycle as the read, it writes that decremented value to the same register exactly once.
- R9: Modes 0 to 5 never assert `rf_we_o`.
- R10: `start_i` is ignored while `busy_o` is high. It causes no extra read, no write-back and no second valid.
- R11: `opnd_valid_o` is a single-cycle pulse. `busy_o` is high from the first cycle after accept up to and including the valid cycle, and is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request; accepted only when idle |
| mode_i | input | 3 | Addressing mode code (0..7) |
| reg_sel_i | input | REG_W | Address register specifier |
| field_i | input | ADDR_W | Constant / address field |
| pc_i | input | ADDR_W | Current program counter |
| rf_raddr_o | output | REG_W | Register-file read address |
| rf_rdata_i | input | DATA_W | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register write-back enable |
| rf_waddr_o | output | REG_W | Write-back register |
| rf_wdata_o | output | DATA_W | Write-back value |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after request |
| busy_o | output | 1 | Operation in progress |
| opnd_valid_o | output | 1 | Operand valid strobe |
| opnd_o | output | DATA_W | Operand value |

## Verification
Some properties are checked by assertions on every cycle. The strobe is a single pulse, and no read is issued on the valid cycle. Every read is followed either by another read or by valid. A write-back happens only alongside a read and never in two cycles in a row. The idle block is quiet, and valid implies busy. The bench scenarios are what show the values: the computed addresses in each mode, including wraparound, the pointer chasing of memory indirect, the operand data, and the written-back register value. They also show latency per mode and the absence of effect from a start pulse while busy.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_IMM     = 3'd0,
    AM_DIR     = 3'd1,
    AM_RIND    = 3'd2,
    AM_MIND    = 3'd3,
    AM_IDX     = 3'd4,
    AM_REL     = 3'd5,
    AM_POSTINC = 3'd6,
    AM_PREDEC  = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_FETCH,
    ST_DONE_MEM,
    ST_DONE_IMM
  } seq_st_e;
endpackage

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  amode_e              mode_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [ADDR_W-1:0]   field_i,
  input  logic [ADDR_W-1:0]   pc_i,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [ADDR_W-1:0]   wb_val_o,
  output logic                wb_en_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] base_dec;
  assign base_dec = base_i - ONE;

  always_comb begin
    ea_o     = field_i;
    wb_val_o = '0;
    wb_en_o  = 1'b0;
    unique case (mode_i)
      AM_IMM, AM_DIR, AM_MIND: ea_o = field_i;  // mem-indirect: pointer address
      AM_RIND:                 ea_o = base_i;
      AM_IDX:                  ea_o = base_i + field_i;
      AM_REL:                  ea_o = pc_i + field_i;
      AM_POSTINC: begin
        ea_o     = base_i;
        wb_val_o = base_i + ONE;
        wb_en_o  = 1'b1;
      end
      AM_PREDEC: begin
        ea_o     = base_dec;
        wb_val_o = base_dec;
        wb_en_o  = 1'b1;
      end
      default: ea_o = field_i;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  amode_e  mode_i,
  output logic    accept_o,
  output seq_st_e state_o
);
  seq_st_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (mode_i == AM_IMM)       state_d = ST_DONE_IMM;
        else if (mode_i == AM_MIND) state_d = ST_PTR;
        else                        state_d = ST_FETCH;
      end
      ST_PTR:      state_d = ST_FETCH;
      ST_FETCH:    state_d = ST_DONE_MEM;
      ST_DONE_MEM: state_d = ST_IDLE;
      ST_DONE_IMM: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
  import agu_pkg::*;
#(
  parameter  int ADDR_W = 16,
  parameter  int DATA_W = 16,
  parameter  int NREG   = 8,
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [REG_W-1:0]  reg_sel_i,
  input  logic [ADDR_W-1:0] field_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [REG_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              opnd_valid_o,
  output logic [DATA_W-1:0] opnd_o
);
  amode_e            mode;
  seq_st_e           state;
  logic              accept;
  logic [ADDR_W-1:0] ea, wb_val;
  logic              wb_en;

  logic [ADDR_W-1:0] ea_q, wb_val_q;
  logic              wb_en_q, ind_q;
  logic [REG_W-1:0]  wb_reg_q;
  logic [DATA_W-1:0] imm_q;

  assign mode       = amode_e'(mode_i);
  assign rf_raddr_o = reg_sel_i;

  agu_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode),
    .accept_o (accept),
    .state_o  (state)
  );

  agu_ea_calc #(.ADDR_W(ADDR_W)) u_ea (
    .mode_i   (mode),
    .base_i   (rf_rdata_i[ADDR_W-1:0]),
    .field_i  (field_i),
    .pc_i     (pc_i),
    .ea_o     (ea),
    .wb_val_o (wb_val),
    .wb_en_o  (wb_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q     <= '0;
      wb_val_q <= '0;
      wb_en_q  <= 1'b0;
      ind_q    <= 1'b0;
      wb_reg_q <= '0;
      imm_q    <= '0;
    end else if (accept) begin
      ea_q     <= ea;
      wb_val_q <= wb_val;
      wb_en_q  <= wb_en;
      ind_q    <= (mode == AM_MIND);
      wb_reg_q <= reg_sel_i;
      imm_q    <= DATA_W'(field_i);
    end
  end

  // second indirect read takes its address straight from the pointer data
  assign mem_re_o     = (state == ST_PTR) || (state == ST_FETCH);
  assign mem_addr_o   = (state == ST_FETCH && ind_q) ? mem_rdata_i[ADDR_W-1:0] : ea_q;
  assign rf_we_o      = (state == ST_FETCH) && wb_en_q;
  assign rf_waddr_o   = wb_reg_q;
  assign rf_wdata_o   = DATA_W'(wb_val_q);
  assign busy_o       = (state != ST_IDLE);
  assign opnd_valid_o = (state == ST_DONE_MEM) || (state == ST_DONE_IMM);
  assign opnd_o       = (state == ST_DONE_MEM) ? mem_rdata_i : imm_q;
endmodule

// File: rtl/opnd_agu_chk.sv
module opnd_agu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mem_re_o,
  input logic rf_we_o,
  input logic busy_o,
  input logic opnd_valid_o
);
  // R11
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_valid_o |=> !opnd_valid_o);
  // R11
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_valid_o |-> busy_o);
  // R2
  valid_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_valid_o |-> !mem_re_o);
  // R5
  read_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (mem_re_o || opnd_valid_o));
  // R7
  wb_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);
  // R9
  wb_with_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> mem_re_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !rf_we_o && !opnd_valid_o));
endmodule

bind opnd_agu opnd_agu_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_re_o     (mem_re_o),
  .rf_we_o      (rf_we_o),
  .busy_o       (busy_o),
  .opnd_valid_o (opnd_valid_o)
);

// File: tb/tb_opnd_agu.sv
`timescale 1ns/1ps
module tb_opnd_agu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_sel_i = '0;
  logic [15:0] field_i = '0;
  logic [15:0] pc_i = '0;
  logic [2:0]  rf_raddr_o;
  logic [15:0] rf_rdata_i;
  logic        rf_we_o;
  logic [2:0]  rf_waddr_o;
  logic [15:0] rf_wdata_o;
  logic        mem_re_o;
  logic [15:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic        busy_o, opnd_valid_o;
  logic [15:0] opnd_o;

  logic [15:0] regs [8];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  opnd_agu dut (.*);

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hA5C3;
  endfunction

  assign rf_rdata_i = regs[rf_raddr_o];
  always @(posedge clk_i) if (rf_we_o) regs[rf_waddr_o] <= rf_wdata_o;
  always @(posedge clk_i) if (mem_re_o) mem_rdata_i <= mem_f(mem_addr_o);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // runs one request, recording reads, write-backs, latency and operand
  task automatic exec(input logic [2:0] m, input logic [2:0] r, input logic [15:0] f,
                      input logic [15:0] p, input bit pester,
                      output int lat, output int nrd, output logic [15:0] a0,
                      output logic [15:0] a1, output int nwb, output logic [2:0] wbr,
                      output logic [15:0] wbv, output logic [15:0] op);
    @(negedge clk_i);
    mode_i = m; reg_sel_i = r; field_i = f; pc_i = p; start_i = 1'b1;
    lat = 0; nrd = 0; nwb = 0; a0 = '0; a1 = '0; wbr = '0; wbv = '0; op = '0;
    @(negedge clk_i);
    lat = 1;
    if (pester) begin
      mode_i = 3'd6; reg_sel_i = 3'd5; field_i = 16'h1234;
    end else start_i = 1'b0;
    while (lat < 12) begin
      if (mem_re_o) begin
        if (nrd == 0) a0 = mem_addr_o; else a1 = mem_addr_o;
        nrd++;
      end
      if (rf_we_o) begin nwb++; wbr = rf_waddr_o; wbv = rf_wdata_o; end
      if (opnd_valid_o) begin op = opnd_o; break; end
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy_o && !opnd_valid_o && !mem_re_o && !rf_we_o, "R1", "outputs in reset",
        {busy_o, opnd_valid_o, mem_re_o, rf_we_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !opnd_valid_o && !mem_re_o && !rf_we_o, "R1", "outputs idle",
        {busy_o, opnd_valid_o, mem_re_o, rf_we_o}, 0);
  endtask

  task automatic t_immediate();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    exec(3'd0, 3'd1, 16'hBEEF, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(lat == 1, "R2", "imm latency", lat, 1);
    chk(nrd == 0, "R2", "imm reads", nrd, 0);
    chk(op == 16'hBEEF, "R2", "imm operand", op, 16'hBEEF);
    chk(nwb == 0, "R9", "imm write-back", nwb, 0);
  endtask

  task automatic t_direct();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    exec(3'd1, 3'd0, 16'h0040, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h0040, "R3", "direct read addr", a0, 16'h0040);
    chk(lat == 2, "R3", "direct latency", lat, 2);
    chk(op == mem_f(16'h0040), "R3", "direct operand", op, mem_f(16'h0040));
    chk(nwb == 0, "R9", "direct write-back", nwb, 0);
  endtask

  task automatic t_reg_ind();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    @(negedge clk_i); regs[2] = 16'h3A17;
    exec(3'd2, 3'd2, 16'h0999, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h3A17, "R4", "reg-ind read addr", a0, 16'h3A17);
    chk(op == mem_f(16'h3A17), "R4", "reg-ind operand", op, mem_f(16'h3A17));
    chk(nwb == 0 && regs[2] == 16'h3A17, "R9", "reg-ind reg kept", regs[2], 16'h3A17);
  endtask

  task automatic t_mem_ind();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op, ptr; logic [2:0] wbr;
    ptr = mem_f(16'h0100);
    exec(3'd3, 3'd0, 16'h0100, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 2, "R5", "mem-ind read count", nrd, 2);
    chk(a0 == 16'h0100, "R5", "mem-ind pointer addr", a0, 16'h0100);
    chk(a1 == ptr, "R5", "mem-ind operand addr", a1, ptr);
    chk(lat == 3, "R5", "mem-ind latency", lat, 3);
    chk(op == mem_f(ptr), "R5", "mem-ind operand", op, mem_f(ptr));
  endtask

  task automatic t_indexed_relative();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    @(negedge clk_i); regs[4] = 16'h1000;
    exec(3'd4, 3'd4, 16'h0234, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h1234, "R6", "indexed addr", a0, 16'h1234);
    chk(op == mem_f(16'h1234), "R6", "indexed operand", op, mem_f(16'h1234));
    @(negedge clk_i); regs[4] = 16'hFFF0;
    exec(3'd4, 3'd4, 16'h0020, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(a0 == 16'h0010, "R6", "indexed wrap addr", a0, 16'h0010);
    exec(3'd5, 3'd4, 16'h0010, 16'h2000, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h2010, "R6", "relative addr", a0, 16'h2010);
    exec(3'd5, 3'd4, 16'h0002, 16'hFFFF, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(a0 == 16'h0001, "R6", "relative wrap addr", a0, 16'h0001);
    chk(op == mem_f(16'h0001), "R6", "relative operand", op, mem_f(16'h0001));
    chk(nwb == 0, "R9", "relative write-back", nwb, 0);
  endtask

  task automatic t_postinc();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    @(negedge clk_i); regs[6] = 16'h0500;
    exec(3'd6, 3'd6, 16'h0, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h0500, "R7", "postinc read addr", a0, 16'h0500);
    chk(op == mem_f(16'h0500), "R7", "postinc operand", op, mem_f(16'h0500));
    chk(nwb == 1 && wbr == 3'd6, "R7", "postinc wb count/reg", {nwb[15:0], 13'd0, wbr}, {16'd1, 16'd6});
    chk(regs[6] == 16'h0501, "R7", "postinc reg value", regs[6], 16'h0501);
    @(negedge clk_i); regs[6] = 16'hFFFF;
    exec(3'd6, 3'd6, 16'h0, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(regs[6] == 16'h0000 && a0 == 16'hFFFF, "R7", "postinc wrap", regs[6], 16'h0000);
  endtask

  task automatic t_predec();
    int lat, nrd, nwb; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    @(negedge clk_i); regs[7] = 16'h0800;
    exec(3'd7, 3'd7, 16'h0, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h07FF, "R8", "predec read addr", a0, 16'h07FF);
    chk(op == mem_f(16'h07FF), "R8", "predec operand", op, mem_f(16'h07FF));
    chk(nwb == 1 && regs[7] == 16'h07FF, "R8", "predec reg value", regs[7], 16'h07FF);
    @(negedge clk_i); regs[7] = 16'h0000;
    exec(3'd7, 3'd7, 16'h0, 16'h0, 1'b0, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(a0 == 16'hFFFF && regs[7] == 16'hFFFF, "R8", "predec wrap", a0, 16'hFFFF);
  endtask

  task automatic t_busy_start();
    int lat, nrd, nwb, extra; logic [15:0] a0, a1, wbv, op; logic [2:0] wbr;
    @(negedge clk_i); regs[5] = 16'h4444;
    exec(3'd1, 3'd0, 16'h0077, 16'h0, 1'b1, lat, nrd, a0, a1, nwb, wbr, wbv, op);
    chk(nrd == 1 && a0 == 16'h0077 && lat == 2, "R10", "busy start reads", a0, 16'h0077);
    chk(nwb == 0, "R10", "busy start write-back", nwb, 0);
    extra = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (mem_re_o || rf_we_o || opnd_valid_o || busy_o) extra++;
    end
    chk(extra == 0, "R11", "quiet after valid", extra, 0);
    chk(regs[5] == 16'h4444, "R10", "pester reg untouched", regs[5], 16'h4444);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'(i * 16'h0101);
    repeat (2) @(negedge clk_i);
    t_reset();
    t_immediate();
    t_direct();
    t_reg_ind();
    t_mem_ind();
    t_indexed_relative();
    t_postinc();
    t_predec();
    t_busy_start();
    summary();
    $finish;
  end
endmodule